// File: doc/BRIEF.md
# Status and control flag unit

This block holds the processor status word of a 16-bit ALU datapath. When the update strobe is high, it takes the ALU result, both operands, the ALU carry-out and an operation class. From these it computes the next condition flags: carry, parity, half-carry, zero, sign and overflow. A byte/word select chooses whether the flags look at the low 8 bits or at the full 16 bits.

The control flags are trap, interrupt enable and direction. They change only on an explicit set or clear command, or on a load of the whole word. The unit shows the complete 16-bit word on a read port. It also brings out three flags as separate outputs: the string step direction, single-step enable and interrupt enable.

All state changes at the rising clock edge, and every output comes from a register.

Top module: `psw_unit`

## Requirements
- R1: After reset `flags_o` reads 0x0002, and `dir_dec_o`, `trap_en_o` and `int_en_o` are all 0.
- R2: The word layout is fixed: carry bit 0, parity bit 2, half-carry bit 4, zero bit 6, sign bit 7, trap bit 8, interrupt enable bit 9, direction bit 10, overflow bit 11. Bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R3: `op_i` selects the operation class: 0 add, 1 subtract, 2 logic, 3 increment, 4 decrement; codes 5 to 7 behave as logic. On an update, add and subtract copy `cout_i` into carry. Increment and decrement leave carry unchanged. Logic clears carry, whatever `cout_i` is.
- R4: On an arithmetic update, half-carry is set exactly when a carry or borrow crosses from bit 3 into bit 4, that is when `a_i[4]^b_i[4]^res_i[4]` is 1. On a logic update, half-carry is cleared.
- R5: On an update, parity is 1 exactly when `res_i[7:0]` holds an even number of one bits. This holds in both byte and word mode.
- R6: On an update, zero and sign look at the selected width. With `byte_i`=1, zero is set when `res_i[7:0]` is 0 and sign is `res_i[7]`. With `byte_i`=0, zero is set when `res_i` is 0 and sign is `res_i[15]`.
- R7: Overflow is computed on the sign bits of the selected width.
  - For add and increment, it is set when the operands have equal signs and the result sign differs from them.
  - For subtract and decrement, it is set when the operand signs differ and the result sign differs from `a_i`.
  - For logic, it is cleared.
- R8: Command 1 on `cmd_i` sets interrupt enable and command 2 clears it. No update or other command changes it.
- R9: Commands 3 and 4 set and clear direction, and commands 5 and 6 set and clear trap. Commands 0 and 7 do nothing. `dir_dec_o` is 1 (step down) while direction is set, and `trap_en_o` follows trap.
- R10: When `load_i` is high, the next word is `load_word_i`, with reserved bits forced as in R2. The load takes priority over an update and a command in the same cycle.
- R11: Without an update or a load, all condition flags keep their value. An update and a command in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | Condition flag update strobe |
| op_i | input | 3 | Operation class of the ALU result |
| byte_i | input | 1 | 1: byte width flags, 0: word width flags |
| a_i | input | 16 | First ALU operand |
| b_i | input | 16 | Second ALU operand |
| res_i | input | 16 | ALU result |
| cout_i | input | 1 | ALU carry/borrow out of the selected width |
| cmd_i | input | 3 | Control flag set/clear command |
| load_i | input | 1 | Whole-word load strobe |
| load_word_i | input | 16 | Word to load |
| flags_o | output | 16 | Status word |
| dir_dec_o | output | 1 | String step direction, 1 = decrement |
| trap_en_o | output | 1 | Single-step enable |
| int_en_o | output | 1 | Interrupt enable |

## Verification
The assertions assume that `res_i`, `cout_i` and the operands belong to one real ALU operation of the stated class and width. They also assume that `cout_i` carries a borrow for subtract. The block does not check that the three inputs agree; it only turns them into flags.

The bench keeps to this contract. For each step it computes the result and carry-out itself from the chosen operands, class and width. The one exception is logic operations: there it drives `cout_i` high on purpose, to show that carry is cleared anyway.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int FLAG_W  = 16;
  localparam int CF_POS  = 0;
  localparam int ONE_POS = 1;
  localparam int PF_POS  = 2;
  localparam int AF_POS  = 4;
  localparam int ZF_POS  = 6;
  localparam int SF_POS  = 7;
  localparam int TF_POS  = 8;
  localparam int IE_POS  = 9;
  localparam int DF_POS  = 10;
  localparam int OF_POS  = 11;

  localparam logic [FLAG_W-1:0] FIXED_ONES = FLAG_W'(1) << ONE_POS;
  localparam logic [FLAG_W-1:0] LOAD_MASK  =
      (FLAG_W'(1) << CF_POS) | (FLAG_W'(1) << PF_POS) | (FLAG_W'(1) << AF_POS) |
      (FLAG_W'(1) << ZF_POS) | (FLAG_W'(1) << SF_POS) | (FLAG_W'(1) << TF_POS) |
      (FLAG_W'(1) << IE_POS) | (FLAG_W'(1) << DF_POS) | (FLAG_W'(1) << OF_POS);

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_LOGIC = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } op_cls_e;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_SET_IE = 3'd1,
    CMD_CLR_IE = 3'd2,
    CMD_SET_DF = 3'd3,
    CMD_CLR_DF = 3'd4,
    CMD_SET_TF = 3'd5,
    CMD_CLR_TF = 3'd6
  } ctl_cmd_e;

  typedef struct packed {
    logic of_f;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } cond_t;

  typedef struct packed {
    logic df;
    logic ie;
    logic tf;
  } ctl_t;
endpackage

// File: rtl/psw_parity.sv
module psw_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         even_o
);
  logic acc;
  always_comb begin
    acc = 1'b0;
    for (int i = 0; i < W; i++) acc = acc ^ d_i[i];
    even_o = ~acc;
  end
endmodule

// File: rtl/psw_cond_calc.sv
module psw_cond_calc
  import psw_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int PW = 8
) (
  input  logic [2:0]    op_i,
  input  logic          byte_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  cond_t         cur_i,
  output cond_t         nxt_o
);
  localparam int MSB_W = DW - 1;
  localparam int MSB_B = BW - 1;

  logic a_s, b_s, r_s, r_zero, half, add_ov, sub_ov, par_even;

  psw_parity #(.W(PW)) u_par (
    .d_i    (res_i[PW-1:0]),
    .even_o (par_even)
  );

  always_comb begin
    a_s    = byte_i ? a_i[MSB_B]   : a_i[MSB_W];
    b_s    = byte_i ? b_i[MSB_B]   : b_i[MSB_W];
    r_s    = byte_i ? res_i[MSB_B] : res_i[MSB_W];
    r_zero = byte_i ? ~|res_i[BW-1:0] : ~|res_i;
    // sum bit 4 xor both operand bits recovers the carry/borrow into bit 4
    half   = a_i[AF_POS] ^ b_i[AF_POS] ^ res_i[AF_POS];
    add_ov = (a_s == b_s) && (r_s != a_s);
    sub_ov = (a_s != b_s) && (r_s != a_s);

    nxt_o.pf = par_even;
    nxt_o.zf = r_zero;
    nxt_o.sf = r_s;
    unique case (op_cls_e'(op_i))
      OP_ADD: begin nxt_o.cf = cout_i;   nxt_o.af = half; nxt_o.of_f = add_ov; end
      OP_SUB: begin nxt_o.cf = cout_i;   nxt_o.af = half; nxt_o.of_f = sub_ov; end
      OP_INC: begin nxt_o.cf = cur_i.cf; nxt_o.af = half; nxt_o.of_f = add_ov; end
      OP_DEC: begin nxt_o.cf = cur_i.cf; nxt_o.af = half; nxt_o.of_f = sub_ov; end
      default: begin nxt_o.cf = 1'b0;    nxt_o.af = 1'b0; nxt_o.of_f = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/psw_ctrl_next.sv
module psw_ctrl_next
  import psw_pkg::*;
(
  input  logic [2:0] cmd_i,
  input  ctl_t       cur_i,
  output ctl_t       nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    unique case (ctl_cmd_e'(cmd_i))
      CMD_SET_IE: nxt_o.ie = 1'b1;
      CMD_CLR_IE: nxt_o.ie = 1'b0;
      CMD_SET_DF: nxt_o.df = 1'b1;
      CMD_CLR_DF: nxt_o.df = 1'b0;
      CMD_SET_TF: nxt_o.tf = 1'b1;
      CMD_CLR_TF: nxt_o.tf = 1'b0;
      default:    nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int PW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [2:0]        op_i,
  input  logic              byte_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [DW-1:0]     res_i,
  input  logic              cout_i,
  input  logic [2:0]        cmd_i,
  input  logic              load_i,
  input  logic [FLAG_W-1:0] load_word_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              dir_dec_o,
  output logic              trap_en_o,
  output logic              int_en_o
);
  logic [FLAG_W-1:0] psw_q, psw_d, ld_word;
  cond_t cond_cur, cond_calc, cond_sel;
  ctl_t  ctl_cur, ctl_nxt;

  assign cond_cur = '{of_f: psw_q[OF_POS], sf: psw_q[SF_POS], zf: psw_q[ZF_POS],
                      af: psw_q[AF_POS], pf: psw_q[PF_POS], cf: psw_q[CF_POS]};
  assign ctl_cur  = '{df: psw_q[DF_POS], ie: psw_q[IE_POS], tf: psw_q[TF_POS]};

  psw_cond_calc #(.DW(DW), .BW(BW), .PW(PW)) u_cond (
    .op_i   (op_i),
    .byte_i (byte_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .res_i  (res_i),
    .cout_i (cout_i),
    .cur_i  (cond_cur),
    .nxt_o  (cond_calc)
  );

  psw_ctrl_next u_ctl (
    .cmd_i (cmd_i),
    .cur_i (ctl_cur),
    .nxt_o (ctl_nxt)
  );

  assign cond_sel = upd_i ? cond_calc : cond_cur;
  assign ld_word  = (load_word_i & LOAD_MASK) | FIXED_ONES;

  always_comb begin
    psw_d          = FIXED_ONES;
    psw_d[CF_POS]  = cond_sel.cf;
    psw_d[PF_POS]  = cond_sel.pf;
    psw_d[AF_POS]  = cond_sel.af;
    psw_d[ZF_POS]  = cond_sel.zf;
    psw_d[SF_POS]  = cond_sel.sf;
    psw_d[OF_POS]  = cond_sel.of_f;
    psw_d[TF_POS]  = ctl_nxt.tf;
    psw_d[IE_POS]  = ctl_nxt.ie;
    psw_d[DF_POS]  = ctl_nxt.df;
    if (load_i) psw_d = ld_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psw_q <= FIXED_ONES;
    else         psw_q <= psw_d;
  end

  assign flags_o   = psw_q;
  assign dir_dec_o = psw_q[DF_POS];
  assign trap_en_o = psw_q[TF_POS];
  assign int_en_o  = psw_q[IE_POS];
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk
  import psw_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic [2:0]        op_i,
  input logic              byte_i,
  input logic [DW-1:0]     res_i,
  input logic [2:0]        cmd_i,
  input logic              load_i,
  input logic [FLAG_W-1:0] load_word_i,
  input logic [FLAG_W-1:0] flags_o,
  input logic              dir_dec_o
);
  // R2
  reserved_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[ONE_POS] && (flags_o[15:12] == 4'h0) && !flags_o[3] && !flags_o[5]);

  // R3
  logic_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && (op_i == 3'd2)) |=>
      (!flags_o[CF_POS] && !flags_o[AF_POS] && !flags_o[OF_POS]));

  // R3
  incdec_keeps_cf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && ((op_i == 3'd3) || (op_i == 3'd4))) |=> $stable(flags_o[CF_POS]));

  // R6
  word_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !load_i && !byte_i && (res_i == '0)) |=> flags_o[ZF_POS]);

  // R8
  ie_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (cmd_i != 3'd1) && (cmd_i != 3'd2)) |=> $stable(flags_o[IE_POS]));

  // R9
  dir_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (cmd_i == 3'd3)) |=> dir_dec_o);

  // R10
  load_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (flags_o == (($past(load_word_i) & LOAD_MASK) | FIXED_ONES)));

  // R11
  cond_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !load_i) |=> ($stable(flags_o[7:0]) && $stable(flags_o[OF_POS])));
endmodule

bind psw_unit psw_unit_chk #(.DW(DW)) u_psw_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_i       (upd_i),
  .op_i        (op_i),
  .byte_i      (byte_i),
  .res_i       (res_i),
  .cmd_i       (cmd_i),
  .load_i      (load_i),
  .load_word_i (load_word_i),
  .flags_o     (flags_o),
  .dir_dec_o   (dir_dec_o)
);

// File: tb/tb_psw_unit.sv
module tb_psw_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        upd_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0, res_i = '0;
  logic        cout_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic        load_i = 1'b0;
  logic [15:0] load_word_i = '0;
  logic [15:0] flags_o;
  logic        dir_dec_o, trap_en_o, int_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model = 16'h0002;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psw_unit dut (.*);

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each queued expectation at the negedge after its edge
  initial begin
    forever begin
      @(negedge clk_i);
      while (exp_q.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {int_en_o, trap_en_o, dir_dec_o, flags_o}, {e[9], e[8], e[10], e});
      end
    end
  end

  task automatic drive(input logic [2:0] op, input logic bm, input logic [15:0] a,
                       input logic [15:0] b, input logic [2:0] cmd, input logic ld,
                       input logic [15:0] lw, input logic up, input string tag);
    logic [15:0] am, bmv, res, n;
    logic [16:0] full;
    logic co, sa, sb, sr;
    bit is_add, is_sub;
    @(negedge clk_i);
    am  = bm ? {8'h00, a[7:0]} : a;
    bmv = bm ? {8'h00, b[7:0]} : b;
    is_add = (op == 3'd0) || (op == 3'd3);
    is_sub = (op == 3'd1) || (op == 3'd4);
    if (is_add) begin
      full = {1'b0, am} + {1'b0, bmv};
      co   = bm ? full[8] : full[16];
      res  = a + b;
    end else if (is_sub) begin
      co  = (am < bmv);
      res = a - b;
    end else begin
      co  = 1'b1;
      res = a ^ b;
    end
    sa = bm ? a[7] : a[15];
    sb = bm ? b[7] : b[15];
    sr = bm ? res[7] : res[15];
    n = model;
    if (ld) n = (lw & 16'h0FD5) | 16'h0002;
    else begin
      if (up) begin
        n[0]  = ((op == 3'd0) || (op == 3'd1)) ? co : (is_add || is_sub) ? model[0] : 1'b0;
        n[2]  = ($countones(res[7:0]) % 2) == 0;
        n[4]  = (is_add || is_sub) ? (a[4] ^ b[4] ^ res[4]) : 1'b0;
        n[6]  = bm ? (res[7:0] == 8'h00) : (res == 16'h0000);
        n[7]  = sr;
        n[11] = is_add ? ((sa == sb) && (sr != sa)) :
                is_sub ? ((sa != sb) && (sr != sa)) : 1'b0;
      end
      case (cmd)
        3'd1: n[9]  = 1'b1;
        3'd2: n[9]  = 1'b0;
        3'd3: n[10] = 1'b1;
        3'd4: n[10] = 1'b0;
        3'd5: n[8]  = 1'b1;
        3'd6: n[8]  = 1'b0;
        default: ;
      endcase
    end
    op_i = op; byte_i = bm; a_i = a; b_i = b; res_i = res; cout_i = co;
    cmd_i = cmd; load_i = ld; load_word_i = lw; upd_i = up;
    @(posedge clk_i);
    model = n;
    exp_q.push_back(n);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(3'd0, 1'b0, 16'h1234, 16'h4321, 3'd0, 1'b0, 16'h0, 1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset", {int_en_o, trap_en_o, dir_dec_o, flags_o}, {3'b000, 16'h0002});
    rst_ni = 1'b1;
    idle("R1 R11 idle after reset");
    // R7 signed overflow on add, R4 half-carry, R5 parity of 0x00
    drive(3'd0, 1'b0, 16'h7FFF, 16'h0001, 3'd0, 1'b0, 16'h0, 1'b1, "R4 R5 R7 add overflow");
    // R3 carry out, R6 word zero
    drive(3'd0, 1'b0, 16'hFFFF, 16'h0001, 3'd0, 1'b0, 16'h0, 1'b1, "R3 R6 add carry zero");
    drive(3'd1, 1'b0, 16'h8000, 16'h0001, 3'd0, 1'b0, 16'h0, 1'b1, "R7 sub overflow");
    drive(3'd1, 1'b0, 16'h0000, 16'h0001, 3'd0, 1'b0, 16'h0, 1'b1, "R3 R4 sub borrow");
    drive(3'd3, 1'b0, 16'h000F, 16'h0001, 3'd0, 1'b0, 16'h0, 1'b1, "R3 inc keeps carry");
    drive(3'd2, 1'b0, 16'h0001, 16'h0002, 3'd0, 1'b0, 16'h0, 1'b1, "R3 R5 logic clears carry");
    drive(3'd0, 1'b1, 16'h1280, 16'h3480, 3'd0, 1'b0, 16'h0, 1'b1, "R6 R7 byte add");
    drive(3'd4, 1'b0, 16'h8000, 16'h0001, 3'd0, 1'b0, 16'h0, 1'b1, "R3 R7 dec keeps carry");
    drive(3'd6, 1'b1, 16'h00F0, 16'h0001, 3'd0, 1'b0, 16'h0, 1'b1, "R3 unused op code as logic");
    drive(3'd0, 1'b0, 16'h7000, 16'h7000, 3'd1, 1'b0, 16'h0, 1'b1, "R8 R11 set IE with update");
    drive(3'd1, 1'b0, 16'h0005, 16'h0003, 3'd0, 1'b0, 16'h0, 1'b1, "R8 update keeps IE");
    idle("R11 hold");
    drive(3'd0, 1'b0, 16'h0, 16'h0, 3'd3, 1'b0, 16'h0, 1'b0, "R9 set direction");
    drive(3'd0, 1'b0, 16'h0, 16'h0, 3'd5, 1'b0, 16'h0, 1'b0, "R9 set trap");
    drive(3'd0, 1'b0, 16'h0, 16'h0, 3'd7, 1'b0, 16'h0, 1'b0, "R9 command 7 no effect");
    drive(3'd0, 1'b0, 16'h0, 16'h0, 3'd4, 1'b0, 16'h0, 1'b0, "R9 clear direction");
    drive(3'd0, 1'b0, 16'h0, 16'h0, 3'd2, 1'b0, 16'h0, 1'b0, "R8 clear IE");
    drive(3'd0, 1'b0, 16'hFFFF, 16'h0001, 3'd1, 1'b1, 16'hFFFF, 1'b1, "R2 R10 load all ones wins");
    drive(3'd0, 1'b0, 16'h0, 16'h0, 3'd0, 1'b1, 16'h0000, 1'b0, "R2 R10 load zero");
    for (int i = 0; i < 400; i++) begin
      drive(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 16'($urandom),
            16'($urandom), 3'($urandom_range(0, 7)), ($urandom_range(0, 15) == 0),
            16'($urandom), 1'($urandom_range(0, 1)), "random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end
    idle("R11 final hold");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule